// File: doc/BRIEF.md
# Two-of-four structured sparsity compressor

The block takes a stream of dense weight vectors and prunes each one to a fixed 50% sparsity pattern. Every input vector is cut into non-overlapping groups of four signed two's-complement elements. In each group the two elements with the largest magnitude survive and the other two are discarded. Only the survivors are emitted, so the value output is half as wide as the input. Each group also produces a small index field that says which of the four lanes each survivor came from. A downstream multiply engine can use these indices to fetch the matching elements of the other, uncompressed operand.

Vectors enter and leave on valid/ready handshakes, one vector per beat, through a two-stage pipeline. Parameters set the element width and the number of groups per vector. When an optional check input is set, the block also raises a per-group flag for any group that held more than two nonzero elements before pruning, which means real data was lost.

Top module: `sparse24_compressor`

## Requirements
- R1: Group g of the input occupies elements 4g..4g+3 of `in_data_i`, where element k is bits [k*ELEM_W +: ELEM_W]. Group g of the output occupies elements 2g and 2g+1 of `out_data_o` and meta bits [4g +: 4]. A group's result depends only on that group's four elements.
- R2: In each group the two elements with the largest magnitude are emitted unmodified, and the other two are dropped.
- R3: When magnitudes are equal, the element in the lower lane ranks higher. An all-zero group therefore keeps lanes 0 and 1.
- R4: Survivors are emitted in ascending lane order. Output element 2g holds the lower lane and its index goes in meta bits [4g +: 2]. Output element 2g+1 holds the higher lane and its index goes in meta bits [4g+2 +: 2]. The upper index is always strictly greater than the lower index.
- R5: Magnitude is the absolute value of the element. The most negative code (-2^(ELEM_W-1)) has the largest magnitude of all codes.
- R6: `out_viol_o[g]` is 1 only if `check_en_i` was 1 when the vector was accepted and group g had three or four nonzero elements. Otherwise it is 0.
- R7: While `out_ready_i` is low, a presented output holds its value, and `in_ready_o` drops once both pipeline stages are full. No vector is lost, duplicated or reordered.
- R8: Suppose an input is accepted on clock edge N and the output is never stalled. Then the result is valid on `out_valid_o` after edge N+1, and the pipeline accepts one vector per cycle.
- R9: While reset is asserted and right after it, `out_valid_o` is 0 and `in_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Dense vector valid |
| in_ready_o | output | 1 | Block can accept a vector |
| in_data_i | input | NUM_GRP*4*ELEM_W | Dense vector, groups of four signed elements |
| check_en_i | input | 1 | Enable the over-density flag for this vector |
| out_valid_o | output | 1 | Compressed vector valid |
| out_ready_i | input | 1 | Consumer accepts the compressed vector |
| out_data_o | output | NUM_GRP*2*ELEM_W | Surviving values, two per group |
| out_meta_o | output | NUM_GRP*4 | Two 2-bit lane indices per group |
| out_viol_o | output | NUM_GRP | Group had more than two nonzeros (check mode only) |

## Verification
The bench targets magnitude ties, such as all-equal groups, +x against -x and all-zero groups. A design that breaks ties by the higher lane, or non-deterministically, would keep the wrong lanes, and in the all-zero case would emit two identical indices. It also feeds the most negative code next to the largest positive one, which exposes an absolute value that wraps back to a negative number and so ranks the most negative element smallest. Check mode is exercised with groups holding exactly two, three and four nonzeros, with the enable on and off, to catch an off-by-one density threshold or a flag that ignores the enable. Random backpressure and a long full stall, checked against a scoreboard, catch overwritten stages and lost or repeated vectors.

// File: rtl/sparse24_pkg.sv
package sparse24_pkg;
  localparam int LANES = 4;
  localparam int KEEP  = 2;
  localparam int IDX_W = 2;
endpackage

// File: rtl/sparse24_group_sel.sv
module sparse24_group_sel
  import sparse24_pkg::*;
#(
  parameter int ELEM_W = 8
) (
  input  logic [LANES*ELEM_W-1:0] grp_i,
  input  logic                    check_en_i,
  output logic [KEEP*IDX_W-1:0]   meta_o,
  output logic                    viol_o
);
  logic [ELEM_W-1:0] mag [LANES];
  logic [LANES-1:0]  nz;
  logic [LANES-1:0]  keep;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [ELEM_W-1:0] e;
    assign e      = grp_i[l*ELEM_W +: ELEM_W];
    // unsigned result: the most negative code maps to 2^(W-1), the maximum
    assign mag[l] = e[ELEM_W-1] ? (~e + 1'b1) : e;
    assign nz[l]  = |e;
  end

  // a lane survives when fewer than KEEP lanes outrank it; lower lane wins ties
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      int beaten;
      beaten = 0;
      for (int j = 0; j < LANES; j++) begin
        if (j < i && mag[j] >= mag[i]) beaten++;
        else if (j > i && mag[j] > mag[i]) beaten++;
      end
      keep[i] = (beaten < KEEP);
    end
  end

  logic [IDX_W-1:0] idx_lo, idx_hi;
  always_comb begin
    logic found;
    found  = 1'b0;
    idx_lo = '0;
    idx_hi = '0;
    for (int i = 0; i < LANES; i++) begin
      if (keep[i]) begin
        if (!found) begin
          idx_lo = IDX_W'(i);
          found  = 1'b1;
        end
        idx_hi = IDX_W'(i);
      end
    end
  end

  assign meta_o = {idx_hi, idx_lo};
  assign viol_o = check_en_i && ($countones(nz) > KEEP);
endmodule

// File: rtl/sparse24_pipe_stage.sv
module sparse24_pipe_stage #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  output logic             ready_o,
  input  logic [WIDTH-1:0] data_i,
  output logic             valid_o,
  input  logic             ready_i,
  output logic [WIDTH-1:0] data_o
);
  logic             valid_q;
  logic [WIDTH-1:0] data_q;

  assign ready_o = !valid_q || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (ready_o) begin
      valid_q <= valid_i;
      if (valid_i) data_q <= data_i;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;

  AST_STAGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && !ready_i |=> valid_q && $stable(data_q)); // R7
endmodule

// File: rtl/sparse24_compressor.sv
module sparse24_compressor
  import sparse24_pkg::*;
#(
  parameter int ELEM_W  = 8,
  parameter int NUM_GRP = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            in_valid_i,
  output logic                            in_ready_o,
  input  logic [NUM_GRP*LANES*ELEM_W-1:0] in_data_i,
  input  logic                            check_en_i,
  output logic                            out_valid_o,
  input  logic                            out_ready_i,
  output logic [NUM_GRP*KEEP*ELEM_W-1:0]  out_data_o,
  output logic [NUM_GRP*KEEP*IDX_W-1:0]   out_meta_o,
  output logic [NUM_GRP-1:0]              out_viol_o
);
  localparam int GRP_W  = LANES * ELEM_W;
  localparam int DIN_W  = NUM_GRP * GRP_W;
  localparam int DOUT_W = NUM_GRP * KEEP * ELEM_W;
  localparam int GMET_W = KEEP * IDX_W;
  localparam int META_W = NUM_GRP * GMET_W;
  localparam int S1_W   = DIN_W + META_W + NUM_GRP;
  localparam int S2_W   = DOUT_W + META_W + NUM_GRP;

  // stage 0: lane selection per group
  logic [META_W-1:0]  sel_meta;
  logic [NUM_GRP-1:0] sel_viol;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_sel
    sparse24_group_sel #(.ELEM_W(ELEM_W)) i_sel (
      .grp_i      (in_data_i[g*GRP_W +: GRP_W]),
      .check_en_i (check_en_i),
      .meta_o     (sel_meta[g*GMET_W +: GMET_W]),
      .viol_o     (sel_viol[g])
    );
  end

  logic             s1_valid, s1_ready;
  logic [S1_W-1:0]  s1_data;

  sparse24_pipe_stage #(.WIDTH(S1_W)) i_stage1 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (in_valid_i),
    .ready_o (in_ready_o),
    .data_i  ({sel_viol, sel_meta, in_data_i}),
    .valid_o (s1_valid),
    .ready_i (s1_ready),
    .data_o  (s1_data)
  );

  logic [DIN_W-1:0]   s1_dense;
  logic [META_W-1:0]  s1_meta;
  logic [NUM_GRP-1:0] s1_viol;
  assign {s1_viol, s1_meta, s1_dense} = s1_data;

  // stage 1: gather surviving values
  logic [DOUT_W-1:0] gath;
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_gath
    logic [ELEM_W-1:0] lane_v [LANES];
    logic [IDX_W-1:0]  lo, hi;
    for (genvar l = 0; l < LANES; l++) begin : g_l
      assign lane_v[l] = s1_dense[g*GRP_W + l*ELEM_W +: ELEM_W];
    end
    assign lo = s1_meta[g*GMET_W +: IDX_W];
    assign hi = s1_meta[g*GMET_W + IDX_W +: IDX_W];
    assign gath[(KEEP*g)*ELEM_W   +: ELEM_W] = lane_v[lo];
    assign gath[(KEEP*g+1)*ELEM_W +: ELEM_W] = lane_v[hi];
  end

  logic [S2_W-1:0] s2_data;

  sparse24_pipe_stage #(.WIDTH(S2_W)) i_stage2 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (s1_valid),
    .ready_o (s1_ready),
    .data_i  ({s1_viol, s1_meta, gath}),
    .valid_o (out_valid_o),
    .ready_i (out_ready_i),
    .data_o  (s2_data)
  );

  assign {out_viol_o, out_meta_o, out_data_o} = s2_data;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_ast
    AST_META_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o |-> out_meta_o[g*GMET_W + IDX_W +: IDX_W] > out_meta_o[g*GMET_W +: IDX_W]); // R4
    AST_VIOL_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o && out_viol_o[g] |->
        (|out_data_o[(KEEP*g)*ELEM_W +: ELEM_W]) && (|out_data_o[(KEEP*g+1)*ELEM_W +: ELEM_W])); // R6
  end

  AST_OUT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)
      && $stable(out_meta_o) && $stable(out_viol_o)); // R7
  AST_FULL_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |-> out_valid_o && !out_ready_i); // R7
endmodule

// File: tb/test_sparse24_compressor.sv
`timescale 1ns/1ps
module test_sparse24_compressor;
  localparam int W    = 8;
  localparam int G    = 4;
  localparam int DIN  = G*4*W;
  localparam int DOUT = G*2*W;
  localparam int META = G*4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [DIN-1:0]  in_data = '0;
  logic            check_en = 1'b0;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic [DOUT-1:0] out_data;
  logic [META-1:0] out_meta;
  logic [G-1:0]    out_viol;

  sparse24_compressor #(.ELEM_W(W), .NUM_GRP(G)) i_sparse24_compressor (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .check_en_i(check_en), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_data_o(out_data), .out_meta_o(out_meta),
    .out_viol_o(out_viol)
  );

  always #4 clk = ~clk;

  typedef struct {
    logic [DOUT-1:0] d;
    logic [META-1:0] m;
    logic [G-1:0]    v;
    string           tag;
    int              acc;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0, cyc = 0;
  bit   lat_mode = 0, rnd_ready = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [DOUT-1:0] act,
                       input logic [DOUT-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [DIN-1:0] din, input bit chk);
    exp_t r;
    r.d = '0; r.m = '0; r.v = '0; r.tag = ""; r.acc = 0;
    for (int g = 0; g < G; g++) begin
      int mag[4];
      int nz, a, b, lo, hi;
      nz = 0;
      for (int l = 0; l < 4; l++) begin
        logic signed [W-1:0] e;
        e = din[(g*4+l)*W +: W];
        mag[l] = (int'(e) < 0) ? -int'(e) : int'(e);
        if (e != 0) nz++;
      end
      a = 0;
      for (int l = 1; l < 4; l++) if (mag[l] > mag[a]) a = l;
      b = -1;
      for (int l = 0; l < 4; l++)
        if (l != a && (b < 0 || mag[l] > mag[b])) b = l;
      lo = (a < b) ? a : b;
      hi = (a < b) ? b : a;
      r.d[(2*g)*W +: W]   = din[(g*4+lo)*W +: W];
      r.d[(2*g+1)*W +: W] = din[(g*4+hi)*W +: W];
      r.m[g*4 +: 2]       = 2'(lo);
      r.m[g*4+2 +: 2]     = 2'(hi);
      r.v[g]              = chk && (nz > 2);
    end
    return r;
  endfunction

  function automatic logic [31:0] mk4(input int e0, input int e1, input int e2, input int e3);
    return {8'(e3), 8'(e2), 8'(e1), 8'(e0)};
  endfunction

  // caller is at a negedge; returns at a negedge with in_valid still high
  task automatic send(input logic [DIN-1:0] din, input bit chk, input string tag);
    bit done;
    done = 0;
    in_valid = 1'b1;
    in_data  = din;
    check_en = chk;
    while (!done) begin
      #3;
      if (in_ready) begin
        exp_t e;
        e = model(din, chk);
        e.tag = tag;
        e.acc = cyc;
        q.push_back(e);
        done = 1;
      end
      @(negedge clk);
    end
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // monitor: pops and compares on every output transfer
  initial begin
    forever begin
      @(negedge clk);
      if (rnd_ready) out_ready = ($urandom % 3) != 0;
      #3;
      if (rst_n && out_valid && out_ready) begin
        if (q.size() == 0) begin
          check(0, "R7 unexpected output", out_data, '0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(out_data == e.d, {e.tag, " R2 values"}, out_data, e.d);
          check(out_meta == e.m, {e.tag, " R4 meta"}, DOUT'(out_meta), DOUT'(e.m));
          check(out_viol == e.v, {e.tag, " R6 flag"}, DOUT'(out_viol), DOUT'(e.v));
          if (lat_mode)
            check(cyc - e.acc == 2, "R8 latency", DOUT'(cyc - e.acc), DOUT'(2));
        end
      end
    end
  end

  initial begin
    #(8*150000);
    check(0, "watchdog", '0, '0);
    summary();
    $finish;
  end

  initial begin
    logic [DOUT-1:0] held;
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R9 valid in reset", DOUT'(out_valid), '0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R9 valid after reset", DOUT'(out_valid), '0);
    check(in_ready == 1'b1, "R9 ready after reset", DOUT'(in_ready), DOUT'(1));
    @(negedge clk);

    lat_mode = 1;
    send({mk4(1,-9,3,7), mk4(100,-2,50,-60), mk4(0,0,5,-6), mk4(10,20,30,40)}, 0, "R2");
    send({mk4(4,4,4,4), mk4(-5,5,-5,5), mk4(0,0,0,0), mk4(3,-7,7,-7)}, 0, "R3");
    send({mk4(-128,127,0,-127), mk4(127,-128,127,1), mk4(-128,-128,-128,-128),
          mk4(-1,-128,2,127)}, 0, "R5");
    send({mk4(1,2,3,4), mk4(0,9,9,9), mk4(0,5,0,-5), mk4(0,0,0,0)}, 1, "R6");
    send({mk4(1,2,3,4), mk4(0,9,9,9), mk4(0,5,0,-5), mk4(0,0,0,0)}, 0, "R6");
    send({mk4(-1,1,-1,1), mk4(127,126,125,124), mk4(0,0,0,1), mk4(2,0,0,0)}, 1, "R1");
    in_valid = 1'b0;
    drain();
    lat_mode = 0;

    // full stall
    out_ready = 1'b0;
    send({mk4(9,8,7,6), mk4(-3,3,-4,4), mk4(1,0,0,0), mk4(5,6,7,8)}, 1, "R7");
    send({mk4(2,3,4,5), mk4(-6,6,-7,7), mk4(0,1,0,0), mk4(8,7,6,5)}, 0, "R7");
    in_valid = 1'b0;
    @(negedge clk);
    #1;
    held = out_data;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      #1;
      check(out_valid == 1'b1, "R7 valid held", DOUT'(out_valid), DOUT'(1));
      check(in_ready == 1'b0, "R7 ready low when full", DOUT'(in_ready), '0);
      check(out_data == held, "R7 data held", out_data, held);
    end
    @(negedge clk);
    out_ready = 1'b1;
    drain();

    // random traffic with random backpressure
    rnd_ready = 1;
    for (int n = 0; n < 300; n++) begin
      logic [DIN-1:0] r;
      for (int k = 0; k < DIN/32; k++) r[k*32 +: 32] = $urandom;
      if (n % 4 == 0) r[31:0] = {8'($urandom % 3), 8'd0, 8'($urandom % 3), 8'd0};
      send(r, ($urandom % 2) == 1, "R1");
      if (n % 7 == 0) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    rnd_ready = 0;
    out_ready = 1'b1;
    drain();
    check(q.size() == 0, "R7 nothing lost", DOUT'(q.size()), '0);

    summary();
    $finish;
  end
endmodule